// File: doc/BRIEF.md
# Iterative Crossbar Port Matcher

This block decides, once per time slot, which inputs of an N-by-N crossbar connect to which outputs. Each input keeps separate queues for every output. A request matrix tells the block which input/output pairs have traffic waiting. The block returns a match matrix with at most one set bit in each row and in each column. The crossbar uses that matrix during the following slot.

A slot begins with a one-cycle `start` pulse, and the request matrix is latched on that cycle. The block then spends one clock per iteration for `ITERS` iterations. Each iteration has three phases:

1. Every free input raises requests towards the free outputs it holds traffic for.
2. Every free output grants one of the inputs that requested it.
3. Every input accepts one of the grants it received, and that pair is fixed.

Ports fixed in an earlier iteration drop out of later iterations. Grant and accept choices come from per-port rotating pointers. A one-cycle `done` strobe shows that `match` holds the new result.

Top module: `xbar_matcher`

## Requirements
- R1: After reset, `match` is all zero and `done` is low.
- R2: In every iteration, each output grants at most one input, and only an input that requested it.
- R3: The final `match` has at most one set bit per row (input) and per column (output). Bit `i*N+j` of `req` and `match` refers to input i and output j.
- R4: A bit of `match` is set only if the same bit of the latched request matrix was set.
- R5: An input or output matched in an earlier iteration of the slot takes no part in later iterations of that slot.
- R6: With `ITERS >= N`, the final `match` is maximal: no requested pair has both its input and its output unmatched.
- R7: `done` is high for exactly one cycle, `ITERS` clock edges after the edge that accepted `start`. `match` changes only on that edge.
- R8: Each output's grant pointer and each input's accept pointer start at port 0. The arbiter picks the first requesting port at or after the pointer, wrapping from N-1 to 0. Both pointers of a pair move to one past the partner port only when that pair is accepted in the first iteration of a slot.
- R9: A `start` pulse that arrives while a slot is in progress is ignored. It does not change the result or the timing of that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a slot and latches `req` |
| req | input | N*N | Request matrix, bit i*N+j means input i has a cell for output j |
| match | output | N*N | Final match matrix, same bit layout as `req` |
| done | output | 1 | One-cycle strobe when `match` is updated |

## Verification
The assertions assume that `start` is a single-cycle pulse. They also assume that `req` is valid on the cycle `start` is high; after that cycle `req` may change freely, because it is latched. The bench drives `start` for exactly one cycle, so a new slot begins only after the previous `done`. The one exception is a deliberate extra `start` pulse in the middle of a slot, used to test R9. Random request matrices are drawn at several densities between sparse and full. Directed cases cover the empty matrix, a single request, full load and a permutation.

// File: rtl/xbm_pkg.sv
package xbm_pkg;
  function automatic int wrap_next(input int v, input int n);
    return (v + 1) % n;
  endfunction
endpackage

// File: rtl/xbm_rr_pick.sv
module xbm_rr_pick #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic [N-1:0]  gnt
);
  always_comb begin
    logic found;
    gnt   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  // R2: one winner at most, and only a requester
  a_r2_one_winner: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  a_r2_from_req:   assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0);
  a_r2_no_starve:  assert property (@(posedge clk) disable iff (!rst_n) (req != '0) |-> (gnt != '0));
endmodule

// File: rtl/xbar_matcher.sv
module xbar_matcher #(
  parameter int N     = 4,
  parameter int ITERS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N*N-1:0] req,
  output logic [N*N-1:0] match,
  output logic         done
);
  import xbm_pkg::*;
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(ITERS + 1);
  localparam int NN = N * N;

  logic          busy_q, busy_d;
  logic [CW-1:0] iter_q, iter_d;
  logic [NN-1:0] req_q, req_d, wm_q, wm_d, match_q, match_d;
  logic          done_q, done_d;
  logic [PW-1:0] gptr_q [N];
  logic [PW-1:0] gptr_d [N];
  logic [PW-1:0] aptr_q [N];
  logic [PW-1:0] aptr_d [N];

  logic [N-1:0]  in_busy, out_busy;
  logic [NN-1:0] act, acc;
  logic [N-1:0]  gcol [N];   // gcol[j][i]: output j grants input i
  logic [N-1:0]  arow [N];   // arow[i][j]: input i accepts output j

  // Ports already matched this slot are masked out of the request phase
  always_comb begin
    in_busy  = '0;
    out_busy = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        in_busy[i]  = in_busy[i]  | wm_q[i*N+j];
        out_busy[j] = out_busy[j] | wm_q[i*N+j];
      end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        act[i*N+j] = req_q[i*N+j] & ~in_busy[i] & ~out_busy[j];
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_grant
      logic [N-1:0] creq;
      always_comb for (int i = 0; i < N; i++) creq[i] = act[i*N+g];
      xbm_rr_pick #(.N(N)) u_gnt (.clk(clk), .rst_n(rst_n), .req(creq), .ptr(gptr_q[g]), .gnt(gcol[g]));
    end
    for (g = 0; g < N; g++) begin : g_accept
      logic [N-1:0] areq;
      always_comb for (int j = 0; j < N; j++) areq[j] = gcol[j][g];
      xbm_rr_pick #(.N(N)) u_acc (.clk(clk), .rst_n(rst_n), .req(areq), .ptr(aptr_q[g]), .gnt(arow[g]));
    end
  endgenerate

  always_comb
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        acc[i*N+j] = arow[i][j];

  // Next-state logic
  always_comb begin
    busy_d  = busy_q;
    iter_d  = iter_q;
    req_d   = req_q;
    wm_d    = wm_q;
    match_d = match_q;
    done_d  = 1'b0;
    gptr_d  = gptr_q;
    aptr_d  = aptr_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        iter_d = '0;
        req_d  = req;
        wm_d   = '0;
      end
    end else begin
      wm_d = wm_q | acc;
      if (iter_q == '0)
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++)
            if (arow[i][j]) begin
              aptr_d[i] = PW'(wrap_next(j, N));
              gptr_d[j] = PW'(wrap_next(i, N));
            end
      if (iter_q == CW'(ITERS - 1)) begin
        busy_d  = 1'b0;
        done_d  = 1'b1;
        match_d = wm_q | acc;
      end else begin
        iter_d = iter_q + 1'b1;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      iter_q  <= '0;
      req_q   <= '0;
      wm_q    <= '0;
      match_q <= '0;
      done_q  <= 1'b0;
      for (int k = 0; k < N; k++) begin
        gptr_q[k] <= '0;
        aptr_q[k] <= '0;
      end
    end else begin
      busy_q  <= busy_d;
      iter_q  <= iter_d;
      req_q   <= req_d;
      wm_q    <= wm_d;
      match_q <= match_d;
      done_q  <= done_d;
      gptr_q  <= gptr_d;
      aptr_q  <= aptr_d;
    end
  end

  assign match = match_q;
  assign done  = done_q;

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r7_hold:         assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(match));
  a_r4_subset:       assert property (@(posedge clk) disable iff (!rst_n) done |-> (match & ~req_q) == '0);
  a_r9_ignore:       assert property (@(posedge clk) disable iff (!rst_n) (busy_q && start) |=> $stable(req_q));
  a_r5_no_rematch:   assert property (@(posedge clk) disable iff (!rst_n) busy_q |-> (acc & ~act) == '0);

  generate
    for (g = 0; g < N; g++) begin : g_chk
      logic [N-1:0] mrow, mcol;
      always_comb for (int k = 0; k < N; k++) begin
        mrow[k] = match[g*N+k];
        mcol[k] = match[k*N+g];
      end
      a_r3_row: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mrow));
      a_r3_col: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mcol));
    end
  endgenerate
endmodule

// File: tb/sim_xbar_matcher.sv
`timescale 1ns/1ps
module sim_xbar_matcher;
  localparam int N = 4;
  localparam int ITERS = 4;
  localparam int NN = N * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NN-1:0] req = '0;
  logic [NN-1:0] match;
  logic done;

  int tests = 0, fails = 0;
  int gp [N];
  int ap [N];

  always #2.5 clk = ~clk;

  xbar_matcher #(.N(N), .ITERS(ITERS)) u0 (.clk(clk), .rst_n(rst_n), .start(start),
    .req(req), .match(match), .done(done));

  task automatic chk(input bit ok, input string r, input logic [NN-1:0] act, input logic [NN-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // Reference model: iterative request/grant/accept with rotating pointers
  function automatic logic [NN-1:0] model(input logic [NN-1:0] r);
    logic [NN-1:0] m = '0;
    for (int it = 0; it < ITERS; it++) begin
      bit ib [N];
      bit ob [N];
      int gsel [N];
      logic [NN-1:0] add = '0;
      for (int k = 0; k < N; k++) begin ib[k] = 0; ob[k] = 0; end
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (m[i*N+j]) begin ib[i] = 1; ob[j] = 1; end
      for (int j = 0; j < N; j++) begin
        gsel[j] = -1;
        for (int k = 0; k < N; k++) begin
          int i = (gp[j] + k) % N;
          if (gsel[j] < 0 && !ob[j] && !ib[i] && r[i*N+j]) gsel[j] = i;
        end
      end
      for (int i = 0; i < N; i++)
        for (int k = 0; k < N; k++) begin
          int j = (ap[i] + k) % N;
          if (gsel[j] == i) begin
            add[i*N+j] = 1'b1;
            break;
          end
        end
      if (it == 0)
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++)
            if (add[i*N+j]) begin ap[i] = (j + 1) % N; gp[j] = (i + 1) % N; end
      m = m | add;
    end
    return m;
  endfunction

  task automatic props(input logic [NN-1:0] r, input logic [NN-1:0] m);
    bit ok3 = 1, ok6 = 1;
    for (int a = 0; a < N; a++) begin
      int rc = 0, cc = 0;
      for (int b = 0; b < N; b++) begin rc += m[a*N+b]; cc += m[b*N+a]; end
      if (rc > 1 || cc > 1) ok3 = 0;
    end
    chk(ok3, "R3 one per row/col", m, m);
    chk((m & ~r) == '0, "R4 subset of req", m, m & r);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        bit fi = 1, fj = 1;
        for (int k = 0; k < N; k++) begin
          if (m[i*N+k]) fi = 0;
          if (m[k*N+j]) fj = 0;
        end
        if (r[i*N+j] && fi && fj) ok6 = 0;
      end
    chk(ok6, "R6 maximal", m, r);
  endtask

  task automatic slot(input logic [NN-1:0] r, input bit extra);
    logic [NN-1:0] exp, prev;
    prev = match;
    exp = model(r);
    @(negedge clk); start = 1'b1; req = r;
    @(negedge clk); start = 1'b0; req = ~r;
    for (int c = 1; c < ITERS; c++) begin
      if (extra && c == 1) start = 1'b1;     // R9 stray start mid-slot
      @(negedge clk);
      start = 1'b0;
    end
    chk(done == 1'b0 && match == prev, "R7 no early done/change", match, prev);
    @(negedge clk);
    chk(done == 1'b1, "R7 done on time", NN'(done), NN'(1));
    chk(match == exp, extra ? "R9 stray start ignored" : "R5 R8 model match", match, exp);
    props(r, match);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", NN'(done), '0);
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin gp[k] = 0; ap[k] = 0; end
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    chk(match == '0 && done == 1'b0, "R1 reset", match, '0);
    rst_n = 1'b1;
    @(negedge clk);
    slot('0, 0);
    slot(NN'(1) << 6, 0);
    for (int s = 0; s < 5; s++) slot('1, 0);   // R8 pointer rotation under full load
    slot(16'h8421, 0);
    slot(16'hF00F, 1);
    for (int s = 0; s < 300; s++) begin
      logic [NN-1:0] r = NN'($urandom);
      case (s % 3)
        0: r = r & NN'($urandom);
        1: r = r | NN'($urandom);
        default: ;
      endcase
      slot(r, (s % 37) == 5);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule